// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the receive half of a serial audio port that runs as a slave. It is clocked by the incoming bit clock and watches the frame clock and the serial data line. From these it rebuilds one left and one right PCM sample per stereo frame. Each sample is returned as a parallel word, and a single-cycle strobe marks a new pair.

One shift engine serves two framings, and the mode input chooses between them at run time. In I2S framing the frame clock level names the channel, and every frame-clock change starts a slot one bit later. In DSP-early framing a rising frame-clock edge starts the frame, the right word follows the left word with no gap, and the bits after it are dropped. A frame that is cut short is not delivered; the block raises an error pulse for it instead. The mode and the word length are taken only when a frame starts, so software may change them at any time.

Top module: `pcm_frame_rx`

## Requirements
- R1: While `rst_n` is low at a rising `bclk` edge, both output words are cleared to zero and `frame_valid` and `frame_err` are driven low.
- R2: With `fmt_sel` = 0 (I2S), a frame-clock change seen on one rising `bclk` edge starts a slot. The word's MSB is taken on the following rising edge. The slot carries the left word while `fsync` is low and the right word while `fsync` is high.
- R3: With `fmt_sel` = 1 (DSP-early), a rising `fsync` edge starts a frame and the left MSB is taken on the next rising `bclk` edge. The right MSB is taken on the edge right after the left LSB. Falling `fsync` edges have no effect.
- R4: In DSP-early framing, the bits that follow the right LSB, up to the next rising frame edge, do not change either output word.
- R5: `wlen_sel` sets the word length n: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits. Bits arrive MSB first. Each output word holds the sample in bits n-1..0, and its upper bits are zero. In I2S framing, slot bits after the n-th bit are ignored.
- R6: `fmt_sel` and `wlen_sel` are captured on the edge that starts a frame. In I2S that is a falling `fsync` edge, and in DSP-early a rising one; when no frame is in progress, the present `fmt_sel` picks which edge counts. Changing either input later in the frame has no effect on that frame.
- R7: `frame_valid` is high for exactly one cycle per complete frame. That cycle directly follows the rising edge on which the right LSB is taken. `left_word` and `right_word` change only in that cycle.
- R8: A word is incomplete when a slot-starting or frame-starting edge arrives before all n of its bits are in. In that case the frame is dropped: no `frame_valid` follows, the output words keep their values, and `frame_err` is high for one cycle.
- R9: No frame-clock edge is recognised on the first rising `bclk` edge after reset. The `fsync` level sampled on that edge becomes the reference for finding later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; every register of the block runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame clock: channel level in I2S, frame-start pulse in DSP-early |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 1 | Framing select: 0 = I2S, 1 = DSP-early |
| wlen_sel | input | 2 | Word length select: 0/1/2/3 = 16/20/24/32 bits |
| left_word | output | 32 | Last complete left sample, right-aligned |
| right_word | output | 32 | Last complete right sample, right-aligned |
| frame_valid | output | 1 | One-cycle strobe when a new stereo pair is published |
| frame_err | output | 1 | One-cycle pulse when a frame is dropped as incomplete |

## Verification
The assertions assume that `fsync`, `sdata`, `fmt_sel` and `wlen_sel` change only between rising `bclk` edges. They also assume that reset is held for at least one edge, so the first sample after reset has a defined predecessor. The stimulus meets both assumptions: every input is driven on the falling bit-clock edge, and reset is held for several cycles. Frames in the stimulus cover each word length in both framings. Some slots and frames are exactly n or 2n bits long; others carry padding bits driven high. Further frames change the mode and length in the middle of a frame, and short frames are cut off early so that the drop path runs.

// File: rtl/pcm_rx_pkg.sv
// Package: shared constants, framing type and word-length decode for the
// serial audio receiver. Assumes a maximum word of 32 bits.
package pcm_rx_pkg;

    localparam int MAX_WL = 32;
    localparam int CNT_W  = $clog2(MAX_WL + 1);

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_DSP = 1'b1
    } fmt_e;

    // Decode the 2-bit length code into a bit count.
    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(16);
            2'd1:    return CNT_W'(20);
            2'd2:    return CNT_W'(24);
            default: return CNT_W'(32);
        endcase
    endfunction

    // Build a mask with the low n bits set.
    function automatic logic [MAX_WL-1:0] wlen_mask(input logic [CNT_W-1:0] n);
        logic [MAX_WL-1:0] m;
        for (int i = 0; i < MAX_WL; i++) begin
            m[i] = (CNT_W'(i) < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/pcm_rx_edge.sv
// Frame-clock edge finder. Compares the frame clock with its copy from
// the previous rising bit-clock edge. Assumes fsync is stable around the
// rising bclk edge. The first edge after reset only loads the reference.
module pcm_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic rise,
    output logic fall
);

    logic fs_q;
    logic primed;

    // Hold the previous frame-clock level and note when it is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            primed <= 1'b0;
        end else begin
            fs_q   <= fsync;
            primed <= 1'b1;
        end
    end

    assign rise = primed &&  fsync && !fs_q;
    assign fall = primed && !fsync &&  fs_q;

    // R9
    edge_is_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |-> (fsync != $past(fsync)));

endmodule

// File: rtl/pcm_rx_seq.sv
// Slot sequencer. Tracks which channel word is being assembled and how
// many bits are in. It also latches the framing and length at frame start
// and detects incomplete words. On each edge it first accounts for the bit
// on the line, then handles any frame-clock edge. Assumes the edge flags
// come from pcm_rx_edge in the same cycle.
module pcm_rx_seq
    import pcm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             fmt_sel,
    input  logic [1:0]       wlen_sel,
    output logic             cap,
    output logic             fin_left,
    output logic             fin_right,
    output logic [CNT_W-1:0] word_len,
    output logic             frame_err
);

    logic             active_q, chan_q;
    logic [CNT_W-1:0] cnt_q, n_q;
    fmt_e             fmt_q;

    logic             active_n, chan_n, err_n;
    logic [CNT_W-1:0] cnt_n, n_n;
    fmt_e             fmt_n;

    logic             a1, c1, waiting, start, swap, word_fin;
    logic [CNT_W-1:0] k1, cnt_inc;
    fmt_e             eff_fmt;

    assign cap       = active_q && (cnt_q < n_q);
    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign word_fin  = cap && (cnt_inc == n_q);
    assign fin_left  = word_fin && !chan_q;
    assign fin_right = word_fin &&  chan_q;
    assign word_len  = n_q;

    // Next state: take this cycle's bit, then apply any frame-clock edge.
    always_comb begin
        a1 = active_q;
        c1 = chan_q;
        k1 = cap ? cnt_inc : cnt_q;
        if (fin_left && fmt_q == FMT_DSP) begin
            c1 = 1'b1;
            k1 = '0;
        end
        if (fin_right) begin
            a1 = 1'b0;
        end
        waiting = a1 && !c1 && (k1 == n_q);
        eff_fmt = active_q ? fmt_q : fmt_e'(fmt_sel);
        start   = (eff_fmt == FMT_I2S) ? fall : rise;
        swap    = active_q && (fmt_q == FMT_I2S) && rise;

        active_n = a1;
        chan_n   = c1;
        cnt_n    = k1;
        n_n      = n_q;
        fmt_n    = fmt_q;
        err_n    = 1'b0;
        if (start) begin
            err_n    = a1;
            active_n = 1'b1;
            chan_n   = 1'b0;
            cnt_n    = '0;
            n_n      = wlen_bits(wlen_sel);
            fmt_n    = fmt_e'(fmt_sel);
        end else if (swap) begin
            if (waiting) begin
                chan_n = 1'b1;
                cnt_n  = '0;
            end else if (a1) begin
                err_n    = 1'b1;
                active_n = 1'b0;
            end
        end
    end

    // Register the sequencing state and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            chan_q    <= 1'b0;
            cnt_q     <= '0;
            n_q       <= wlen_bits(2'd0);
            fmt_q     <= FMT_I2S;
            frame_err <= 1'b0;
        end else begin
            active_q  <= active_n;
            chan_q    <= chan_n;
            cnt_q     <= cnt_n;
            n_q       <= n_n;
            fmt_q     <= fmt_n;
            frame_err <= err_n;
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= n_q));

    // R5
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q == 16 || n_q == 20 || n_q == 24 || n_q == 32));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(n_q) && $stable(fmt_q)));

endmodule

// File: rtl/pcm_rx_shift.sv
// Shift and publish stage. Shifts serial bits in MSB first and parks the
// finished left word. Both words are published together with the valid
// strobe when the right word completes. Assumes cap/fin_* come from
// pcm_rx_seq for the same edge.
module pcm_rx_shift
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              cap,
    input  logic              fin_left,
    input  logic              fin_right,
    input  logic [CNT_W-1:0]  word_len,
    output logic [MAX_WL-1:0] left_word,
    output logic [MAX_WL-1:0] right_word,
    output logic              valid
);

    logic [MAX_WL-1:0] sh_q, sh_next, mask, left_stage;

    assign sh_next = {sh_q[MAX_WL-2:0], sdata};
    assign mask    = wlen_mask(word_len);

    // Shift in data, stage the left word, publish the pair on right finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            left_stage <= '0;
            left_word  <= '0;
            right_word <= '0;
            valid      <= 1'b0;
        end else begin
            if (cap) begin
                sh_q <= sh_next;
            end
            if (fin_left) begin
                left_stage <= sh_next & mask;
            end
            if (fin_right) begin
                left_word  <= left_stage;
                right_word <= sh_next & mask;
            end
            valid <= fin_right;
        end
    end

    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left_word) && $stable(right_word)));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/pcm_frame_rx.sv
// Top of the serial audio receiver. Everything runs on the bit clock.
// Assumes all inputs are stable around the rising bclk edge.
module pcm_frame_rx
    import pcm_rx_pkg::*;
(
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              fmt_sel,
    input  logic [1:0]        wlen_sel,
    output logic [MAX_WL-1:0] left_word,
    output logic [MAX_WL-1:0] right_word,
    output logic              frame_valid,
    output logic              frame_err
);

    logic             rise, fall, cap, fin_left, fin_right;
    logic [CNT_W-1:0] word_len;

    pcm_rx_edge u_edge (
        .clk   (bclk),
        .rst_n (rst_n),
        .fsync (fsync),
        .rise  (rise),
        .fall  (fall)
    );

    pcm_rx_seq u_seq (
        .clk       (bclk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .fmt_sel   (fmt_sel),
        .wlen_sel  (wlen_sel),
        .cap       (cap),
        .fin_left  (fin_left),
        .fin_right (fin_right),
        .word_len  (word_len),
        .frame_err (frame_err)
    );

    pcm_rx_shift u_shift (
        .clk        (bclk),
        .rst_n      (rst_n),
        .sdata      (sdata),
        .cap        (cap),
        .fin_left   (fin_left),
        .fin_right  (fin_right),
        .word_len   (word_len),
        .left_word  (left_word),
        .right_word (right_word),
        .valid      (frame_valid)
    );

    // R8
    valid_err_excl_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !(frame_valid && frame_err));

endmodule

// File: tb/pcm_frame_rx_tb.sv
// Scoreboard bench: frame driver tasks queue the expected outcome, and a
// monitor on the falling edge pops and compares each strobe.
module pcm_frame_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b1;
    logic        sdata = 1'b0;
    logic        fmt_sel = 1'b1;
    logic [1:0]  wlen_sel = 2'd0;
    logic [31:0] left_word, right_word;
    logic        frame_valid, frame_err;

    typedef struct packed {
        bit          is_err;
        logic [31:0] l;
        logic [31:0] r;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    logic        pend = 1'b0;
    logic        cur_fmt = 1'b1;
    logic [1:0]  cur_ws = 2'd0;
    logic [31:0] prev_l = '0, prev_r = '0;
    bit          finished = 1'b0;
    int          cyc = 0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    pcm_frame_rx u_dut (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .sdata       (sdata),
        .fmt_sel     (fmt_sel),
        .wlen_sel    (wlen_sel),
        .left_word   (left_word),
        .right_word  (right_word),
        .frame_valid (frame_valid),
        .frame_err   (frame_err)
    );

    function automatic int wbits(input logic [1:0] ws);
        case (ws)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] lowmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bit period: the data line lags the intended bit by one cycle.
    task automatic tick(input logic fs, input logic b);
        @(negedge bclk);
        fsync    <= fs;
        sdata    <= pend;
        fmt_sel  <= cur_fmt;
        wlen_sel <= cur_ws;
        pend = b;
    endtask

    task automatic idle(input int k, input logic fs);
        for (int i = 0; i < k; i++) tick(fs, 1'b0);
    endtask

    // I2S frame (R2, R5, R6, R8); left_short > 0 cuts the left slot.
    task automatic i2s_frame(input logic [1:0] ws, input int slot, input logic [31:0] l,
                             input logic [31:0] r, input int left_short, input bit mid_cfg);
        int   n;
        int   lslot;
        exp_t e;
        n     = wbits(ws);
        lslot = (left_short > 0) ? left_short : slot;
        e.is_err = (lslot < n);
        e.l = l & lowmask(n);
        e.r = r & lowmask(n);
        q.push_back(e);
        cur_fmt = 1'b0;
        cur_ws  = ws;
        for (int j = 0; j < lslot; j++) begin
            if (mid_cfg && j == 3) begin
                cur_fmt = 1'b1;
                cur_ws  = ~ws;
            end
            tick(1'b0, (j < n) ? l[n-1-j] : 1'b1);
        end
        for (int j = 0; j < slot; j++) begin
            tick(1'b1, (j < n) ? r[n-1-j] : 1'b1);
        end
        cur_fmt = 1'b0;
        cur_ws  = ws;
    endtask

    // DSP-early frame (R3, R4, R5, R8): pulse, left, right, padding of ones.
    task automatic dsp_frame(input logic [1:0] ws, input int total,
                             input logic [31:0] l, input logic [31:0] r);
        int   n;
        exp_t e;
        logic b;
        n = wbits(ws);
        e.is_err = (total < 2 * n);
        e.l = l & lowmask(n);
        e.r = r & lowmask(n);
        q.push_back(e);
        cur_fmt = 1'b1;
        cur_ws  = ws;
        for (int j = 0; j < total; j++) begin
            if (j < n)          b = l[n-1-j];
            else if (j < 2 * n) b = r[2*n-1-j];
            else                b = 1'b1;
            tick(j == 0, b);
        end
    endtask

    // Monitor: pop an expectation on each strobe and compare.
    always @(negedge bclk) begin
        exp_t e;
        if (rst_n && !finished) begin
            if (frame_valid || frame_err) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7/R8/R9 unexpected strobe", {30'd0, frame_err, frame_valid}, 32'd0);
                end else begin
                    e = q.pop_front();
                    if (e.is_err) begin
                        check(frame_err && !frame_valid, "R8 drop pulse",
                              {30'd0, frame_err, frame_valid}, 32'd2);
                        check(left_word == prev_l && right_word == prev_r, "R8 words kept",
                              left_word, prev_l);
                    end else begin
                        check(frame_valid && !frame_err, "R7 valid strobe",
                              {30'd0, frame_err, frame_valid}, 32'd1);
                        check(left_word == e.l, "R2/R3/R5/R6 left word", left_word, e.l);
                        check(right_word == e.r, "R2/R3/R4/R5/R6 right word", right_word, e.r);
                    end
                end
            end
            if (!frame_valid && (left_word != prev_l || right_word != prev_r)) begin
                check(1'b0, "R7 words moved without strobe", left_word, prev_l);
            end
        end
        prev_l = left_word;
        prev_r = right_word;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge bclk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with fsync high and DSP-early selected (for R9)
        repeat (4) @(negedge bclk);
        check(left_word == 32'd0, "R1 left reset", left_word, 32'd0);
        check(right_word == 32'd0, "R1 right reset", right_word, 32'd0);
        check(frame_valid == 1'b0, "R1 valid reset", {31'd0, frame_valid}, 32'd0);
        check(frame_err == 1'b0, "R1 err reset", {31'd0, frame_err}, 32'd0);
        rst_n <= 1'b1;
        // R9: the high level at release must not count as a rising edge
        idle(3, 1'b1);
        idle(2, 1'b0);
        // R3/R4: DSP-early at each length, exact and padded
        dsp_frame(2'd0, 40, 32'hA5C3_1234, 32'h0000_BEEF);
        dsp_frame(2'd2, 48, 32'h00C0_FFEE, 32'h0012_3456);
        dsp_frame(2'd3, 70, 32'h8000_0001, 32'h7FFF_FFFE);
        dsp_frame(2'd1, 50, 32'h000F_0F0F, 32'h000A_AAAA);
        // R8: short DSP frame, then a good one
        dsp_frame(2'd1, 30, 32'h0001_2345, 32'h0006_789A);
        dsp_frame(2'd0, 36, $urandom, $urandom);
        // Switch to I2S with fsync high first (rise ignored while idle)
        cur_fmt = 1'b0;
        idle(2, 1'b1);
        // R2/R5: I2S frames, exact slots and slots with trailing ones
        i2s_frame(2'd3, 32, 32'hDEAD_BEEF, 32'h1357_9BDF, 0, 1'b0);
        i2s_frame(2'd0, 32, 32'h0000_8001, 32'h0000_7FFE, 0, 1'b0);
        i2s_frame(2'd2, 24, 32'h00AB_CDEF, 32'h0080_0001, 0, 1'b0);
        // R6: mode and length change in mid frame
        i2s_frame(2'd1, 32, 32'h000C_3A5F, 32'h0009_1E2D, 0, 1'b1);
        // R8: short left slot, then a good frame
        i2s_frame(2'd2, 32, 32'h0055_AA55, 32'h00AA_55AA, 10, 1'b0);
        i2s_frame(2'd0, 16, $urandom, $urandom, 0, 1'b0);
        idle(3, 1'b1);
        // Back to DSP-early; falling edge while idle is ignored
        cur_fmt = 1'b1;
        idle(2, 1'b0);
        dsp_frame(2'd3, 64, $urandom, $urandom);
        idle(6, 1'b0);
        // R7: every queued frame produced exactly one strobe
        check(q.size() == 0, "R7 pending frames", q.size(), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule